// File: doc/BRIEF.md
# I2C Bus Status and Error Monitor

This block sits beside the byte shifter of an I2C master and watches the raw SCL and SDA pins. It keeps three status flags that software reads through an 8-bit read-only status byte. The busy flag follows START and STOP conditions from any master on the bus. The acknowledge flag holds the level seen in the most recent acknowledge slot. The transmit-error flag records a mismatch between the bit this interface drives and the level actually present on SDA.

The shifter tells the block whether it is driving SDA in the current bit (`drive_en`) and which value it drives (`drive_bit`). The block returns the final pull-down request for the SDA pad. When clock-synchronisation mode is on, a transmit error suppresses that pull-down until the byte in progress has ended. When that mode is off, driving continues as usual. A one-cycle pulse on `ctrl_wr` stands for a write to the control register and clears the error flag. `enable` comes from the mode register; while it is low, all three flags stay at zero.

Top module: `i2c_bus_status_mon`

## Requirements
- R1: `status` is 00h after reset. Bit 0 is busy, bit 1 is the received acknowledge and bit 2 is the transmit error. Bits 7 to 3 always read 0.
- R2: A START condition (SDA falls while SCL is high) sets busy, whether or not this interface is driving. Both pins pass through a two-flop synchroniser, so the flag changes on the third rising clock edge after the pin change.
- R3: A STOP condition (SDA rises while SCL is high) clears busy, with the same latency as R2.
- R4: The bits of a byte are counted on SCL rising edges from a START or from the end of the previous byte. On the ninth SCL rise, which is the acknowledge slot, the synchronised SDA level is stored in bit 1 (0 = ACK, 1 = NACK).
- R5: On an SCL rise with `drive_en` = 1, the error flag (bit 2) is set if `drive_bit` differs from the synchronised SDA level. Bits that this interface does not drive never set it.
- R6: A `ctrl_wr` pulse clears the error flag. A mismatch detected in the same cycle takes precedence and leaves the flag set.
- R7: While `enable` = 0, status bits 2 to 0 are 0, the bit counter rests at 0 and `sda_pull_low` is 0.
- R8: With `sync_mode` = 1, a mismatch forces `sda_pull_low` to 0. This lasts until the end of the current byte, which is the SCL falling edge after the acknowledge slot.
- R9: With `sync_mode` = 0, a set error flag has no effect on `sda_pull_low`.
- R10: When SDA is not blanked, `sda_pull_low` = `enable` & `drive_en` & ~`drive_bit`. A `drive_bit` of 0 pulls the line low and 1 releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable from the mode register |
| sync_mode | input | 1 | Clock-synchronisation mode select |
| ctrl_wr | input | 1 | One-cycle pulse on a control register write |
| scl_pin | input | 1 | Raw SCL line level |
| sda_pin | input | 1 | Raw SDA line level |
| drive_en | input | 1 | Shifter is driving SDA in this bit |
| drive_bit | input | 1 | Value the shifter drives onto SDA |
| status | output | 8 | Read-only status byte |
| sda_pull_low | output | 1 | Pull-down request for the SDA pad |

## Verification
A wrong bit count shows up at the ports within one byte: the acknowledge flag captures a data bit instead of the acknowledge level, and a blanking window closes on the wrong SCL fall. A stuck synchroniser or a faulty edge detector makes busy miss a START or STOP, and the difference appears three clocks after the pin change. A blank flag that fails to release keeps `sda_pull_low` low through the following byte. The bench compares every output on every clock, so any of these faults is reported in the cycle it first becomes visible.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int STATUS_W = 8;

  typedef struct packed {
    logic err;
    logic ack;
    logic busy;
  } mon_flags_t;

  function automatic logic [STATUS_W-1:0] pack_status(input mon_flags_t f);
    logic [STATUS_W-1:0] r;
    r = '0;
    r[0] = f.busy;
    r[1] = f.ack;
    r[2] = f.err;
    return r;
  endfunction

  // SDA moves while SCL stays high on both samples
  function automatic logic is_start(input logic scl_now, input logic scl_prev,
                                    input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & sda_prev & ~sda_now;
  endfunction

  function automatic logic is_stop(input logic scl_now, input logic scl_prev,
                                   input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & ~sda_prev & sda_now;
  endfunction

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond_det.sv
module i2c_mon_cond_det
  import i2c_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = is_start(scl_s, scl_d, sda_s, sda_d);
  assign stop_evt  = is_stop(scl_s, scl_d, sda_s, sda_d);
endmodule

// File: rtl/i2c_mon_bit_tracker.sv
module i2c_mon_bit_tracker #(
  parameter int BITS_PER_BYTE = 8,
  localparam int ACK_IDX = BITS_PER_BYTE,
  localparam int LAST    = BITS_PER_BYTE + 1,
  localparam int CNT_W   = $clog2(BITS_PER_BYTE + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic             ack_slot,
  output logic             byte_end,
  output logic [CNT_W-1:0] bit_cnt
);
  assign ack_slot = enable & scl_rise & (bit_cnt == CNT_W'(ACK_IDX));
  assign byte_end = enable & scl_fall & (bit_cnt == CNT_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (!enable || start_evt || stop_evt || byte_end) begin
      bit_cnt <= '0;
    end else if (scl_rise && bit_cnt != CNT_W'(LAST)) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bus_status_mon.sv
module i2c_bus_status_mon
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BITS_PER_BYTE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                sync_mode,
  input  logic                ctrl_wr,
  input  logic                scl_pin,
  input  logic                sda_pin,
  input  logic                drive_en,
  input  logic                drive_bit,
  output logic [STATUS_W-1:0] status,
  output logic                sda_pull_low
);
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 2);

  logic [1:0]       pins_s;
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic             ack_slot, byte_end;
  logic [CNT_W-1:0] bit_cnt;
  logic             mismatch_evt;
  logic             blank;
  mon_flags_t       flags;

  i2c_mon_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_pin, sda_pin}), .q(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_mon_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_mon_bit_tracker #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_trk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .ack_slot(ack_slot), .byte_end(byte_end), .bit_cnt(bit_cnt)
  );

  assign mismatch_evt = enable & scl_rise & drive_en & (drive_bit ^ sda_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      blank <= 1'b0;
    end else if (!enable) begin
      flags <= '0;
      blank <= 1'b0;
    end else begin
      if (start_evt)     flags.busy <= 1'b1;
      else if (stop_evt) flags.busy <= 1'b0;
      if (ack_slot) flags.ack <= sda_s;
      if (mismatch_evt) flags.err <= 1'b1;
      else if (ctrl_wr) flags.err <= 1'b0;
      if (mismatch_evt && sync_mode) blank <= 1'b1;
      else if (byte_end)             blank <= 1'b0;
    end
  end

  assign status       = pack_status(flags);
  assign sda_pull_low = enable & drive_en & ~drive_bit & ~blank;
endmodule

// File: rtl/i2c_mon_checker.sv
module i2c_mon_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       sync_mode,
  input logic       ctrl_wr,
  input logic [7:0] status,
  input logic       sda_pull_low,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       ack_slot,
  input logic       mismatch_evt,
  input logic       blank,
  input logic       sda_s
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:3] == 5'b0);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && enable) |=> status[0]);
  a_r3_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && enable) |=> !status[0]);
  a_r4_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slot |=> (status[1] == $past(sda_s)));
  a_r5_mismatch_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> status[2]);
  a_r6_write_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !mismatch_evt) |=> !status[2]);
  a_r7_disabled_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (status[2:0] == 3'b0));
  a_r8_blank_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !sda_pull_low);
  a_r9_blank_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank) |-> $past(sync_mode));
endmodule

bind i2c_bus_status_mon i2c_mon_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
  .ctrl_wr(ctrl_wr), .status(status), .sda_pull_low(sda_pull_low),
  .start_evt(start_evt), .stop_evt(stop_evt), .ack_slot(ack_slot),
  .mismatch_evt(mismatch_evt), .blank(blank), .sda_s(sda_s)
);

// File: tb/test_i2c_bus_status_mon.sv
module test_i2c_bus_status_mon;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, sync_mode = 1'b0, ctrl_wr = 1'b0;
  logic scl_pin = 1'b1, sda_pin = 1'b1;
  logic drive_en = 1'b0, drive_bit = 1'b1;
  logic [7:0] status;
  logic sda_pull_low;

  int n_checks = 0;
  int n_fail = 0;

  i2c_bus_status_mon i_i2c_bus_status_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .ctrl_wr(ctrl_wr), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .drive_en(drive_en), .drive_bit(drive_bit),
    .status(status), .sda_pull_low(sda_pull_low)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history queue, integer byte position
  logic [1:0] hist[$];
  bit m_busy, m_ack, m_err, m_blank;
  int m_pos;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {2'b11, 2'b11, 2'b11, 2'b11};
      m_busy = 0; m_ack = 0; m_err = 0; m_blank = 0; m_pos = 0;
    end else begin
      bit sc, sd, pc, pd, rise, fall, sta, sto, mism, bend;
      hist.push_back({scl_pin, sda_pin});
      void'(hist.pop_front());
      sc = hist[1][1]; sd = hist[1][0];
      pc = hist[0][1]; pd = hist[0][0];
      rise = sc && !pc;
      fall = !sc && pc;
      sta = sc && pc && pd && !sd;
      sto = sc && pc && !pd && sd;
      if (!enable) begin
        m_busy = 0; m_ack = 0; m_err = 0; m_blank = 0; m_pos = 0;
      end else begin
        mism = rise && drive_en && (drive_bit != sd);
        bend = fall && (m_pos == 9);
        if (sta) m_busy = 1;
        if (sto) m_busy = 0;
        if (rise && m_pos == 8) m_ack = sd;
        if (mism) m_err = 1;
        else if (ctrl_wr) m_err = 0;
        if (mism && sync_mode) m_blank = 1;
        else if (bend) m_blank = 0;
        if (sta || sto || bend) m_pos = 0;
        else if (rise && m_pos < 9) m_pos++;
      end
    end
    #2;
    begin
      bit exp_pull;
      exp_pull = enable && drive_en && !drive_bit && !m_blank;
      check(status[7:3] == 0, "R1 upper bits", status, 0);
      check(status[0] == m_busy, "R2/R3 busy", status[0], m_busy);
      check(status[1] == m_ack, "R4 ack", status[1], m_ack);
      check(status[2] == m_err, "R5/R6 err", status[2], m_err);
      check(sda_pull_low == exp_pull, "R10 sda_pull_low", sda_pull_low, exp_pull);
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); scl_pin = 1; sda_pin = 1; ticks(Q);
    sda_pin = 0; ticks(Q);
    scl_pin = 0; ticks(Q);
  endtask

  task automatic do_stop();
    @(negedge clk); sda_pin = 0; drive_en = 0; ticks(Q);
    scl_pin = 1; ticks(Q);
    sda_pin = 1; ticks(Q + 2);
  endtask

  // one SCL pulse; line = SDA level on the bus
  task automatic do_bit(input bit line, input bit den, input bit dbit);
    @(negedge clk); sda_pin = line; drive_en = den; drive_bit = dbit; ticks(Q);
    scl_pin = 1; ticks(2*Q);
    scl_pin = 0; ticks(Q);
  endtask

  task automatic do_byte(input logic [7:0] line, input bit den, input logic [7:0] dbits,
                         input bit ack_line);
    for (int i = 7; i >= 0; i--) do_bit(line[i], den, dbits[i]);
    do_bit(ack_line, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    ticks(3);
    check(status == 8'h00, "R1 reset value", status, 0);
    rst_n = 1; ticks(2);
    enable = 1; ticks(2);

    // foreign master transfer, not driven by this interface
    do_start(); ticks(3);
    check(status[0] == 1, "R2 busy after START", status[0], 1);
    do_byte(8'hA5, 0, 8'hFF, 1'b0);
    check(status[1] == 0, "R4 ACK captured", status[1], 0);
    check(status[2] == 0, "R5 undriven bits no error", status[2], 0);
    do_byte(8'h3C, 0, 8'hFF, 1'b1);
    check(status[1] == 1, "R4 NACK captured", status[1], 1);
    do_stop();
    check(status[0] == 0, "R3 busy cleared by STOP", status[0], 0);

    // own transfer, no clock sync
    sync_mode = 0;
    do_start();
    do_byte(8'h96, 1, 8'h96, 1'b0);
    check(status[2] == 0, "R5 matching bits no error", status[2], 0);
    do_bit(1'b0, 1, 1'b1);
    check(status[2] == 1, "R5 mismatch sets error", status[2], 1);
    @(negedge clk); sda_pin = 0; drive_en = 1; drive_bit = 0; ticks(1);
    check(sda_pull_low == 1, "R9 drive continues without sync", sda_pull_low, 1);
    ticks(Q); scl_pin = 1; ticks(2*Q); scl_pin = 0; ticks(Q);
    @(negedge clk); ctrl_wr = 1; @(negedge clk); ctrl_wr = 0; ticks(1);
    check(status[2] == 0, "R6 write clears error", status[2], 0);
    for (int i = 0; i < 6; i++) do_bit(1'b0, 1, 1'b0);
    do_bit(1'b1, 0, 1'b1);

    // clock sync: blank until byte end
    sync_mode = 1;
    do_bit(1'b0, 1, 1'b1);
    check(status[2] == 1, "R5 mismatch in sync mode", status[2], 1);
    @(negedge clk); sda_pin = 0; drive_en = 1; drive_bit = 0; ticks(1);
    check(sda_pull_low == 0, "R8 blanked after error", sda_pull_low, 0);
    ticks(Q); scl_pin = 1; ticks(2*Q); scl_pin = 0; ticks(Q);
    for (int i = 0; i < 6; i++) do_bit(1'b0, 1, 1'b0);
    check(sda_pull_low == 0, "R8 still blanked mid-byte", sda_pull_low, 0);
    do_bit(1'b0, 0, 1'b1);
    @(negedge clk); drive_en = 1; drive_bit = 0; sda_pin = 0; ticks(1);
    check(sda_pull_low == 1, "R8 released after byte end", sda_pull_low, 1);
    ticks(Q); scl_pin = 1; ticks(2*Q); scl_pin = 0; ticks(Q);
    do_stop();

    // disable
    do_start();
    enable = 0; drive_en = 1; drive_bit = 0; ticks(2);
    check(status[2:0] == 0, "R7 flags zero when disabled", status[2:0], 0);
    check(sda_pull_low == 0, "R7 no drive when disabled", sda_pull_low, 0);
    drive_en = 0;
    do_stop();
    do_start(); ticks(3);
    check(status[0] == 0, "R7 START ignored when disabled", status[0], 0);
    do_stop();

    ticks(5);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule